// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block is one DMA channel that copies elements from a source address to a destination address. Software loads a 32-bit settings word, both start addresses, an element length, a block/repeat count and an address offset with a one-cycle load strobe. The channel then waits for a hardware request or a software start. Each element is moved with one read and one write on a simple valid/ready memory port. The interrupt line pulses either after every transfer or only at the end, depending on a settings bit.

Four sequencing modes are provided: normal, repeat, block and repeat-block. In repeat mode the length reloads after each pass, for the programmed number of passes. In the two block modes a single request moves a whole block. In every mode other than normal, one pointer (the repeat area, source or destination) rewinds to its start at each reload. Each pointer is updated after every element. It can stay fixed, move by the programmed offset, or step up or down by the element size. Remaining length and remaining block count are visible as status outputs.

Top module: `dma_seq_channel`

## Requirements
- R1: The settings word is decoded as: bits 31:30 mode (0 normal, 1 repeat, 2 block, 3 repeat-block), bits 29:28 element size (0 one byte, 1 two bytes, 2 four bytes), bits 27:26 source address mode, bit 21 interrupt select, bit 20 repeat area (0 destination, 1 source), bits 19:18 destination address mode. All other bits have no effect.
- R2: After every element, each pointer is updated according to its address mode: 0 unchanged, 1 plus the programmed offset, 2 plus the element size in bytes, 3 minus the element size in bytes.
- R3: In normal mode each request moves exactly one element and decrements the remaining length. Once the length is zero, requests are ignored. A length of zero at load means nothing is ever moved.
- R4: In repeat mode, when the length reaches zero, the block count decrements. If the count is still non-zero, the length and the repeat-area pointer reload their loaded values. When the count reaches zero, requests are ignored.
- R5: In block and repeat-block modes each request moves a full block of length elements. The repeat-area pointer then returns to its loaded value, the length reloads and the block count decrements. The channel stops at a count of zero.
- R6: With interrupt select 1, the interrupt pulses for one cycle after every transfer (an element in normal or repeat mode, a block in the block modes). With select 0, it pulses once, after the final transfer.
- R7: When the enable input is low, a transfer already in progress completes, and requests arriving while it is low cause no transfer.
- R8: A single software start moves one transfer. A repeating software start moves transfers back to back until the channel completes. A software stop ends a repeating start after the current transfer.
- R9: A request that arrives while a transfer is busy is held as one pending flag and is served right after the current transfer.
- R10: `remain_len` and `remain_blk` always show the current remaining length and block count.
- R11: Each element is a read of `mem_size` at the source pointer followed by a write of the read data at the destination pointer. A request holds its address and direction stable until `mem_ready`, and the port is quiet while the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load strobe for all configuration inputs |
| cfg_word | input | 32 | Settings word |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_len | input | LW | Elements per pass or block |
| cfg_blocks | input | LW | Repeat or block count |
| cfg_offset | input | AW | Offset for offset address mode |
| ch_en | input | 1 | Channel enable level |
| hw_req | input | 1 | Hardware transfer request |
| sw_start | input | 1 | Software start, single transfer |
| sw_start_rep | input | 1 | Software start, repeating until completion |
| sw_stop | input | 1 | Software stop of a repeating start |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory byte address |
| mem_size | output | 2 | Element size code |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Memory accepts the request (read data valid) |
| mem_rdata | input | DW | Read data |
| irq | output | 1 | Interrupt pulse |
| busy | output | 1 | A transfer is in progress |
| remain_len | output | LW | Remaining length |
| remain_blk | output | LW | Remaining block/repeat count |

## Verification
The main sequencing is tried with one pattern per mode. A normal linear copy with byte elements separates increment from the end-of-length stop. A halfword copy with a decrementing source and a fixed destination separates the decrement and fixed modes, and it also exercises the per-transfer interrupt. A word-sized repeat run with a rewinding destination shows that reload and count exhaustion happen on the right element. A byte block run with an offset source that rewinds shows that a whole block is moved per request. A halfword repeat-block run with an offset destination, stopped halfway, separates a reload from an end. A zero-length load checks that nothing moves. Directed cases cover the pending flag, disabling during a block, and single, repeating and stopped software starts, all under a memory that stalls every third cycle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    XM_NORMAL = 2'd0,
    XM_REPEAT = 2'd1,
    XM_BLOCK  = 2'd2,
    XM_RING   = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    AM_FIXED  = 2'd0,
    AM_OFFSET = 2'd1,
    AM_INC    = 2'd2,
    AM_DEC    = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  typedef struct packed {
    xfer_mode_e mode;
    logic [1:0] size;
    addr_mode_e src_am;
    logic       irq_each;
    logic       area_src;
    addr_mode_e dst_am;
  } xfer_cfg_t;

  localparam int unsigned MODE_LSB = 30;
  localparam int unsigned SIZE_LSB = 28;
  localparam int unsigned SAM_LSB  = 26;
  localparam int unsigned IRQ_BIT  = 21;
  localparam int unsigned AREA_BIT = 20;
  localparam int unsigned DAM_LSB  = 18;

  function automatic xfer_cfg_t decode_cfg(input logic [31:0] w);
    xfer_cfg_t c;
    c.mode     = xfer_mode_e'(w[MODE_LSB +: 2]);
    c.size     = w[SIZE_LSB +: 2];
    c.src_am   = addr_mode_e'(w[SAM_LSB +: 2]);
    c.irq_each = w[IRQ_BIT];
    c.area_src = w[AREA_BIT];
    c.dst_am   = addr_mode_e'(w[DAM_LSB +: 2]);
    return c;
  endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  addr_mode_e    am,
  input  logic [1:0]    size,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] nxt
);

  logic [AW-1:0] elem_bytes;

  always_comb begin
    unique case (size)
      2'd0:    elem_bytes = AW'(1);
      2'd1:    elem_bytes = AW'(2);
      default: elem_bytes = AW'(4);
    endcase
  end

  always_comb begin
    unique case (am)
      AM_FIXED:  nxt = ptr;
      AM_OFFSET: nxt = ptr + offset;
      AM_INC:    nxt = ptr + elem_bytes;
      default:   nxt = ptr - elem_bytes;
    endcase
  end

endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  input  logic idle,
  input  logic done,
  input  logic hw_req,
  input  logic sw_start,
  input  logic sw_start_rep,
  input  logic sw_stop,
  output logic go
);

  logic pend_q, pend_d;
  logic run_q, run_d;
  logic req_evt;

  assign req_evt = hw_req | sw_start;
  assign go      = idle & en & ~done & (req_evt | pend_q | run_q);

  always_comb begin
    pend_d = pend_q;
    if (clear || !en || done || idle) begin
      pend_d = 1'b0;
    end else if (req_evt) begin
      pend_d = 1'b1;
    end
  end

  always_comb begin
    run_d = run_q;
    if (clear || sw_stop || done || !en) begin
      run_d = 1'b0;
    end else if (sw_start_rep) begin
      run_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      run_q  <= run_d;
    end
  end

endmodule

// File: rtl/dma_seq_channel.sv
module dma_seq_channel
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [31:0]   cfg_word,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [LW-1:0] cfg_len,
  input  logic [LW-1:0] cfg_blocks,
  input  logic [AW-1:0] cfg_offset,
  input  logic          ch_en,
  input  logic          hw_req,
  input  logic          sw_start,
  input  logic          sw_start_rep,
  input  logic          sw_stop,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq,
  output logic          busy,
  output logic [LW-1:0] remain_len,
  output logic [LW-1:0] remain_blk
);

  localparam logic [LW-1:0] ONE = LW'(1);

  seq_state_e    state_q, state_d;
  xfer_cfg_t     cfg_q, cfg_ld;
  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [AW-1:0] src0_q, dst0_q, off_q;
  logic [AW-1:0] src_step, dst_step;
  logic [LW-1:0] len_q, len_d, len0_q;
  logic [LW-1:0] blk_q, blk_d;
  logic [DW-1:0] data_q, data_d;
  logic          done_q, done_d, done_ld;
  logic          irq_q, irq_d;
  logic          go, idle;
  logic          elem_last, blk_last, xfer_end;

  assign cfg_ld  = decode_cfg(cfg_word);
  assign done_ld = (cfg_len == '0) | ((cfg_ld.mode != XM_NORMAL) & (cfg_blocks == '0));
  assign idle    = (state_q == ST_IDLE);

  dma_req_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (cfg_load),
    .en           (ch_en),
    .idle         (idle),
    .done         (done_q),
    .hw_req       (hw_req),
    .sw_start     (sw_start),
    .sw_start_rep (sw_start_rep),
    .sw_stop      (sw_stop),
    .go           (go)
  );

  dma_addr_step #(.AW(AW)) u_src_step (
    .ptr    (src_q),
    .am     (cfg_q.src_am),
    .size   (cfg_q.size),
    .offset (off_q),
    .nxt    (src_step)
  );

  dma_addr_step #(.AW(AW)) u_dst_step (
    .ptr    (dst_q),
    .am     (cfg_q.dst_am),
    .size   (cfg_q.size),
    .offset (off_q),
    .nxt    (dst_step)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    src_d     = src_q;
    dst_d     = dst_q;
    len_d     = len_q;
    blk_d     = blk_q;
    done_d    = done_q;
    data_d    = data_q;
    irq_d     = 1'b0;
    xfer_end  = 1'b0;
    elem_last = (len_q == ONE);
    blk_last  = (blk_q == ONE);
    unique case (state_q)
      ST_IDLE: begin
        if (go) state_d = ST_READ;
      end
      ST_READ: begin
        if (mem_ready) begin
          data_d  = mem_rdata;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (mem_ready) begin
          src_d = src_step;
          dst_d = dst_step;
          len_d = len_q - ONE;
          if (cfg_q.mode == XM_NORMAL) begin
            xfer_end = 1'b1;
            if (elem_last) done_d = 1'b1;
          end else if (elem_last) begin
            xfer_end = 1'b1;
            blk_d    = blk_q - ONE;
            if (blk_last) done_d = 1'b1;
            else          len_d  = len0_q;
            if (cfg_q.area_src) src_d = src0_q;
            else                dst_d = dst0_q;
          end else begin
            xfer_end = (cfg_q.mode == XM_REPEAT);
          end
          state_d = xfer_end ? ST_IDLE : ST_READ;
          irq_d   = xfer_end & (cfg_q.irq_each | done_d);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      src0_q  <= '0;
      dst0_q  <= '0;
      off_q   <= '0;
      len_q   <= '0;
      len0_q  <= '0;
      blk_q   <= '0;
      data_q  <= '0;
      done_q  <= 1'b1;
      irq_q   <= 1'b0;
    end else if (cfg_load) begin
      state_q <= ST_IDLE;
      cfg_q   <= cfg_ld;
      src_q   <= cfg_src;
      dst_q   <= cfg_dst;
      src0_q  <= cfg_src;
      dst0_q  <= cfg_dst;
      off_q   <= cfg_offset;
      len_q   <= cfg_len;
      len0_q  <= cfg_len;
      blk_q   <= cfg_blocks;
      done_q  <= done_ld;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      len_q   <= len_d;
      blk_q   <= blk_d;
      data_q  <= data_d;
      done_q  <= done_d;
      irq_q   <= irq_d;
    end
  end

  assign mem_valid  = (state_q == ST_READ) | (state_q == ST_WRITE);
  assign mem_write  = (state_q == ST_WRITE);
  assign mem_addr   = (state_q == ST_WRITE) ? dst_q : src_q;
  assign mem_size   = cfg_q.size;
  assign mem_wdata  = data_q;
  assign irq        = irq_q;
  assign busy       = ~idle;
  assign remain_len = len_q;
  assign remain_blk = blk_q;

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic          busy,
  input logic          irq,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [LW-1:0] remain_len,
  input logic [1:0]    mode_q,
  input logic          done_q
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid); // R11

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !cfg_load) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write))); // R11

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R6

  AST_DONE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !busy && !cfg_load) |=> !busy); // R3

  AST_NORMAL_LEN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 && !cfg_load) |=> (remain_len <= $past(remain_len))); // R10

endmodule

bind dma_seq_channel dma_seq_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .busy       (busy),
  .irq        (irq),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_write  (mem_write),
  .mem_addr   (mem_addr),
  .remain_len (remain_len),
  .mode_q     (cfg_q.mode),
  .done_q     (done_q)
);

// File: tb/test_dma_seq_channel.sv
module test_dma_seq_channel;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LW = 16;
  localparam int DW = 32;

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  size;
    logic [1:0]  sam;
    logic [1:0]  dam;
    logic        area;
    logic        irqe;
    logic [15:0] len;
    logic [15:0] blk;
    logic [7:0]  off;
    logic [3:0]  nreq;
    logic [7:0]  ewr;
    logic [15:0] eaddr;
    logic [15:0] esrc;
    logic [15:0] elen;
    logic [15:0] eblk;
    logic [3:0]  eirq;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 16'd4, 16'd0, 8'd0, 4'd6, 8'd4, 16'h0083, 16'h0043, 16'd0, 16'd0, 4'd1},
    '{2'd0, 2'd1, 2'd3, 2'd0, 1'b0, 1'b1, 16'd3, 16'd0, 8'd0, 4'd3, 8'd3, 16'h0080, 16'h003C, 16'd0, 16'd0, 4'd3},
    '{2'd1, 2'd2, 2'd2, 2'd2, 1'b0, 1'b0, 16'd2, 16'd2, 8'd0, 4'd6, 8'd4, 16'h0084, 16'h004C, 16'd0, 16'd0, 4'd1},
    '{2'd2, 2'd0, 2'd1, 2'd2, 1'b1, 1'b1, 16'd3, 16'd2, 8'd3, 4'd3, 8'd6, 16'h0085, 16'h0046, 16'd0, 16'd0, 4'd2},
    '{2'd3, 2'd1, 2'd2, 2'd1, 1'b0, 1'b0, 16'd2, 16'd3, 8'd8, 4'd2, 8'd4, 16'h0088, 16'h0046, 16'd2, 16'd1, 4'd0},
    '{2'd0, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 16'd0, 16'd0, 8'd0, 4'd2, 8'd0, 16'h0000, 16'h0000, 16'd0, 16'd0, 4'd0}
  };

  logic          clk, rst_n;
  logic          cfg_load;
  logic [31:0]   cfg_word;
  logic [AW-1:0] cfg_src, cfg_dst, cfg_offset;
  logic [LW-1:0] cfg_len, cfg_blocks;
  logic          ch_en, hw_req, sw_start, sw_start_rep, sw_stop;
  logic          mem_valid, mem_write, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          irq, busy;
  logic [LW-1:0] remain_len, remain_blk;

  logic [7:0]  mem [256];
  int          checks, errors, cyc;
  int          wr_cnt, rd_cnt, irq_cnt;
  logic [15:0] last_waddr;
  logic [31:0] last_wdata;

  dma_seq_channel #(.AW(AW), .LW(LW), .DW(DW)) i_dma_seq_channel (
    .clk, .rst_n, .cfg_load, .cfg_word, .cfg_src, .cfg_dst, .cfg_len,
    .cfg_blocks, .cfg_offset, .ch_en, .hw_req, .sw_start, .sw_start_rep,
    .sw_stop, .mem_valid, .mem_write, .mem_addr, .mem_size, .mem_wdata,
    .mem_ready, .mem_rdata, .irq, .busy, .remain_len, .remain_blk
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] init_byte(input logic [7:0] a);
    return a ^ 8'hA5;
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] s);
    return (s == 2'd0) ? 32'h0000_00FF : (s == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_data(input logic [7:0] a, input logic [1:0] s);
    logic [31:0] w;
    w = {init_byte(a + 8'd3), init_byte(a + 8'd2), init_byte(a + 8'd1), init_byte(a)};
    return w & size_mask(s);
  endfunction

  // R1: settings word field positions
  function automatic logic [31:0] mk_word(input logic [1:0] mode, input logic [1:0] size,
      input logic [1:0] sam, input logic [1:0] dam, input logic area, input logic irqe);
    return {mode, size, sam, 4'b0000, irqe, area, dam, 18'h0};
  endfunction

  // Memory model: combinational read, stall every third cycle
  assign mem_rdata = {mem[mem_addr[7:0] + 8'd3], mem[mem_addr[7:0] + 8'd2],
                      mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};

  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= ((cyc % 3) != 2);
  end

  always @(posedge clk) begin
    if (mem_valid && mem_ready && mem_write) begin
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (mem_size != 2'd0) mem[mem_addr[7:0] + 8'd1] <= mem_wdata[15:8];
      if (mem_size == 2'd2) begin
        mem[mem_addr[7:0] + 8'd2] <= mem_wdata[23:16];
        mem[mem_addr[7:0] + 8'd3] <= mem_wdata[31:24];
      end
      wr_cnt     <= wr_cnt + 1;
      last_waddr <= mem_addr;
      last_wdata <= mem_wdata & size_mask(mem_size);
    end
    if (mem_valid && mem_ready && !mem_write) rd_cnt <= rd_cnt + 1;
    if (irq) irq_cnt <= irq_cnt + 1;
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] w, input logic [15:0] len, input logic [15:0] blk,
                      input logic [7:0] off);
    @(negedge clk);
    cfg_word = w; cfg_src = 16'h0040; cfg_dst = 16'h0080;
    cfg_len = len; cfg_blocks = blk; cfg_offset = {8'h00, off};
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    wr_cnt = 0; rd_cnt = 0; irq_cnt = 0; last_waddr = '0; last_wdata = '0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    @(negedge clk);
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_hw();
    hw_req = 1'b1;
    @(negedge clk);
    hw_req = 1'b0;
    wait_idle();
  endtask

  initial begin
    string rq;
    checks = 0; errors = 0; cyc = 0;
    wr_cnt = 0; rd_cnt = 0; irq_cnt = 0; last_waddr = '0; last_wdata = '0;
    mem_ready = 1'b1;
    for (int i = 0; i < 256; i++) mem[i] = init_byte(8'(i));
    rst_n = 1'b0; cfg_load = 1'b0; cfg_word = '0; cfg_src = '0; cfg_dst = '0;
    cfg_len = '0; cfg_blocks = '0; cfg_offset = '0;
    ch_en = 1'b0; hw_req = 1'b0; sw_start = 1'b0; sw_start_rep = 1'b0; sw_stop = 1'b0;
    repeat (3) @(negedge clk);
    // Reset state (R10, R11)
    check("R11", "reset mem_valid", {31'b0, mem_valid}, 32'd0);
    check("R6", "reset irq", {31'b0, irq}, 32'd0);
    check("R10", "reset remain_len", {16'b0, remain_len}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    ch_en = 1'b1;

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      case (VECS[v].mode)
        2'd0: rq = "R3";
        2'd1: rq = "R4";
        default: rq = "R5";
      endcase
      load(mk_word(VECS[v].mode, VECS[v].size, VECS[v].sam, VECS[v].dam,
                   VECS[v].area, VECS[v].irqe), VECS[v].len, VECS[v].blk, VECS[v].off);
      for (int r = 0; r < int'(VECS[v].nreq); r++) pulse_hw();
      check(rq, "write count", wr_cnt, {24'b0, VECS[v].ewr});
      check("R11", "reads equal writes", rd_cnt, wr_cnt);
      if (VECS[v].ewr != 0) begin
        check("R2", "last write address", {16'b0, last_waddr}, {16'b0, VECS[v].eaddr});
        check("R1", "last write data", last_wdata, exp_data(VECS[v].esrc[7:0], VECS[v].size));
      end
      check("R10", "remain_len", {16'b0, remain_len}, {16'b0, VECS[v].elen});
      check("R10", "remain_blk", {16'b0, remain_blk}, {16'b0, VECS[v].eblk});
      check("R6", "irq pulses", irq_cnt, {28'b0, VECS[v].eirq});
    end

    // R9: request during busy is latched once
    load(mk_word(2'd0, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0), 16'd4, 16'd0, 8'd0);
    hw_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    hw_req = 1'b0;
    wait_idle();
    check("R9", "pending served", wr_cnt, 2);
    check("R9", "remain after pending", {16'b0, remain_len}, 32'd2);

    // R7: disabled requests ignored
    ch_en = 1'b0;
    pulse_hw();
    check("R7", "no transfer while disabled", wr_cnt, 2);
    check("R7", "length untouched", {16'b0, remain_len}, 32'd2);

    // R7: disable during a block lets the block finish
    ch_en = 1'b1;
    load(mk_word(2'd2, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0), 16'd3, 16'd2, 8'd0);
    hw_req = 1'b1;
    @(negedge clk);
    hw_req = 1'b0;
    ch_en = 1'b0;
    wait_idle();
    check("R7", "block completed", wr_cnt, 3);
    check("R7", "block count", {16'b0, remain_blk}, 32'd1);
    pulse_hw();
    check("R7", "later request ignored", wr_cnt, 3);
    ch_en = 1'b1;

    // R8: single software start
    load(mk_word(2'd0, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0), 16'd3, 16'd0, 8'd0);
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    wait_idle();
    check("R8", "single start moves one", wr_cnt, 1);

    // R8: repeating software start runs to completion
    load(mk_word(2'd0, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0), 16'd5, 16'd0, 8'd0);
    sw_start_rep = 1'b1;
    @(negedge clk);
    sw_start_rep = 1'b0;
    repeat (60) @(negedge clk);
    check("R8", "repeat start completes", wr_cnt, 5);
    check("R6", "single end irq", irq_cnt, 1);

    // R8: software stop halts after current element
    load(mk_word(2'd0, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0), 16'd8, 16'd0, 8'd0);
    sw_start_rep = 1'b1;
    @(negedge clk);
    sw_start_rep = 1'b0;
    repeat (6) @(negedge clk);
    sw_stop = 1'b1;
    @(negedge clk);
    sw_stop = 1'b0;
    wait_idle();
    begin
      int n0;
      n0 = wr_cnt;
      check("R8", "stopped early", {31'b0, (n0 >= 1 && n0 < 8)}, 32'd1);
      check("R8", "remain matches moved", {16'b0, remain_len}, 32'(8 - n0));
      repeat (30) @(negedge clk);
      check("R8", "no transfer after stop", wr_cnt, n0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule